// File: doc/BRIEF.md
# I/O Port Permission Bitmap Checker

This block decides whether an unprivileged task may perform a port I/O access of 1, 2 or 4 bytes. The decision comes from a permission bitmap stored inside the task's state segment. When a check is started, the block first validates the current task segment descriptor. A segment that is absent, is not of type 9, or has a limit under 103 faults at once.

For a valid segment the block performs two 16-bit reads through a simple request/response memory port. The first read fetches the bitmap's starting byte offset, stored at segment offset 0x66. The second read fetches the 16-bit bitmap word that covers the port. The access passes only when every bitmap bit covering the accessed ports is clear. In every other case it raises a general-protection fault, whose error code is zero.

The privilege comparison that decides whether a check is needed lies outside this block. So does the translation of the read addresses.

Top module: `io_perm_checker`

## Requirements
- R1: On a start, if `seg_present` is 0, `seg_type` is not 9, or `seg_limit` is below 103, the block raises `done` with `gp_fault` = 1 on the cycle after the start. It issues no memory read for that check.
- R2: For a valid segment, the first read goes to `seg_base + 0x66`, and its 16-bit response is taken as the bitmap offset.
- R3: The bitmap byte offset equals the bitmap offset plus `port_addr >> 3`, summed without truncation to 16 bits. The second read goes to `seg_base` plus that byte offset, modulo 2^32.
- R4: When the byte offset plus 1 is greater than `seg_limit`, the check faults after the first read, and the second read is never issued. A byte offset plus 1 equal to the limit is allowed.
- R5: The permission window is made of bits `p .. p+n-1` of the second read's 16-bit response, where bit 0 is the LSB, `p = port_addr[2:0]`, and `n` is `acc_size` in bytes (1, 2 or 4). The window may cross bit 7 into bit 8.
- R6: The access is allowed (`allow` = 1) only when every window bit is 0. Otherwise `gp_fault` = 1, and `fault_code` is 0.
- R7: Only one read is outstanding at a time. `mem_req` stays high with `mem_addr` stable until `mem_rvalid` arrives. `mem_req` is low outside a read.
- R8: `done` is a one-cycle pulse. While it is high, exactly one of `allow` and `gp_fault` is 1. Both are 0 while `done` is low.
- R9: Inputs are captured on the accepted start. A start, or changes to the descriptor or port inputs, while a check is in progress have no effect on that check.
- R10: While reset is high, and on the cycle after it, `done`, `allow`, `gp_fault` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a check; accepted only when idle |
| seg_present | input | 1 | Task segment present flag |
| seg_type | input | 4 | Task segment type field |
| seg_base | input | ADDR_W | Task segment base address |
| seg_limit | input | ADDR_W | Task segment limit (last valid byte offset) |
| port_addr | input | PORT_W | I/O port address |
| acc_size | input | 3 | Access size in bytes (1, 2, 4) |
| mem_req | output | 1 | Read request, held until response |
| mem_addr | output | ADDR_W | Read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 16 | Read response data |
| done | output | 1 | One-cycle completion pulse |
| allow | output | 1 | Access permitted (with done) |
| gp_fault | output | 1 | General-protection fault (with done) |
| fault_code | output | 16 | Fault error code, always zero |

## Verification
The table-driven tests are chosen so that each one separates a specific way the check could go wrong:
- **Descriptor:** each of the three descriptor failures is tried on its own, so a missing or wrongly ordered validity test shows up as a memory read or a pass.
- **Window position and width:** bitmap words with a single set bit at, next to, or just past the window edge reveal off-by-one window placement and wrong size masks. Among them are windows at bit offset 5 and 7 that cross into the upper byte.
- **Limit boundary:** a pair of cases with byte offset plus 1 equal to the limit, and one beyond it, pins the limit comparison.
- **Offset sum:** a case with offset 0xFFFF and port 0xFFFF exposes a sum truncated to 16 bits.
- **Read timing:** response latencies from zero to three waits exercise the held request.
- **Capture:** a directed case restarts with a bad descriptor mid-check and expects the original verdict.

// File: rtl/iop_pkg.sv
package iop_pkg;

    localparam int          MAP_W          = 16;
    localparam logic [3:0]  TSS_AVAIL_TYPE = 4'd9;
    localparam logic [15:0] MAP_PTR_OFS    = 16'h0066;
    localparam int          MIN_SEG_LIMIT  = 103;
    localparam logic [15:0] FAULT_ERR_CODE = 16'h0000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_OFS,
        ST_RD_MAP,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic pass;
        logic fault;
    } verdict_t;

    localparam verdict_t VERDICT_NONE  = '{pass: 1'b0, fault: 1'b0};
    localparam verdict_t VERDICT_PASS  = '{pass: 1'b1, fault: 1'b0};
    localparam verdict_t VERDICT_FAULT = '{pass: 1'b0, fault: 1'b1};

    // Ones in the low nbytes positions: 1 -> 0x1, 2 -> 0x3, 4 -> 0xF.
    function automatic logic [MAP_W-1:0] size_mask(input logic [2:0] nbytes);
        return MAP_W'((32'd1 << nbytes) - 32'd1);
    endfunction

endpackage

// File: rtl/iop_desc_check.sv
module iop_desc_check
    import iop_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              present,
    input  logic [3:0]        seg_type,
    input  logic [ADDR_W-1:0] limit,
    output logic              desc_ok
);

    localparam logic [ADDR_W-1:0] LIMIT_FLOOR = ADDR_W'(MIN_SEG_LIMIT);

    always_comb begin
        desc_ok = present && (seg_type == TSS_AVAIL_TYPE) && (limit >= LIMIT_FLOOR);
    end

endmodule

// File: rtl/iop_window.sv
module iop_window
    import iop_pkg::*;
(
    input  logic [MAP_W-1:0] map_word,
    input  logic [2:0]       bit_sel,
    input  logic [2:0]       nbytes,
    output logic             deny
);

    logic [MAP_W-1:0] shifted;

    always_comb begin
        shifted = map_word >> bit_sel;
        deny    = |(shifted & size_mask(nbytes));
    end

    // R5: a one-byte access looks at exactly the selected bit
    always_comb begin
        if (!$isunknown({map_word, bit_sel, nbytes}) && nbytes == 3'd1) begin
            p_single_bit_r5: assert (deny == map_word[bit_sel]);
        end
    end

endmodule

// File: rtl/iop_seq.sv
module iop_seq
    import iop_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              desc_ok,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic [PORT_W-1:0] port_addr,
    input  logic [2:0]        acc_size,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [MAP_W-1:0]  mem_rdata,
    output logic [2:0]        bit_sel,
    output logic [2:0]        nbytes,
    input  logic              map_deny,
    output logic              idle,
    output logic              done,
    output verdict_t          verdict
);

    localparam int SHIFT_W = PORT_W - 3;
    localparam int OFS_W   = ((MAP_W > SHIFT_W) ? MAP_W : SHIFT_W) + 1;
    localparam int CMP_W   = ADDR_W + 1;

    seq_state_t        state;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] limit_q;
    logic [PORT_W-1:0] port_q;
    logic [2:0]        size_q;
    logic [OFS_W-1:0]  ofs_q;
    verdict_t          verdict_q;

    logic [OFS_W-1:0]  ofs_sum;
    logic [CMP_W-1:0]  ofs_end;
    logic              over_limit;

    always_comb begin
        ofs_sum    = OFS_W'(mem_rdata) + OFS_W'(port_q >> 3);
        ofs_end    = CMP_W'(ofs_sum) + CMP_W'(1);
        over_limit = ofs_end > CMP_W'(limit_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            base_q    <= '0;
            limit_q   <= '0;
            port_q    <= '0;
            size_q    <= '0;
            ofs_q     <= '0;
            verdict_q <= VERDICT_NONE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        base_q  <= seg_base;
                        limit_q <= seg_limit;
                        port_q  <= port_addr;
                        size_q  <= acc_size;
                        if (desc_ok) begin
                            state <= ST_RD_OFS;
                        end else begin
                            verdict_q <= VERDICT_FAULT;
                            state     <= ST_DONE;
                        end
                    end
                end
                ST_RD_OFS: begin
                    if (mem_rvalid) begin
                        if (over_limit) begin
                            verdict_q <= VERDICT_FAULT;
                            state     <= ST_DONE;
                        end else begin
                            ofs_q <= ofs_sum;
                            state <= ST_RD_MAP;
                        end
                    end
                end
                ST_RD_MAP: begin
                    if (mem_rvalid) begin
                        verdict_q <= map_deny ? VERDICT_FAULT : VERDICT_PASS;
                        state     <= ST_DONE;
                    end
                end
                default: begin
                    verdict_q <= VERDICT_NONE;
                    state     <= ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_RD_OFS: mem_addr = base_q + ADDR_W'(MAP_PTR_OFS);
            ST_RD_MAP: mem_addr = base_q + ADDR_W'(ofs_q);
            default:   mem_addr = '0;
        endcase
        mem_req = (state == ST_RD_OFS) || (state == ST_RD_MAP);
        idle    = (state == ST_IDLE);
        done    = (state == ST_DONE);
        verdict = done ? verdict_q : VERDICT_NONE;
        bit_sel = port_q[2:0];
        nbytes  = size_q;
    end

    // R8: completion lasts a single cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: a waiting request keeps its address until answered
    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: rtl/io_perm_checker.sv
module io_perm_checker
    import iop_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              seg_present,
    input  logic [3:0]        seg_type,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic [PORT_W-1:0] port_addr,
    input  logic [2:0]        acc_size,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [15:0]       mem_rdata,
    output logic              done,
    output logic              allow,
    output logic              gp_fault,
    output logic [15:0]       fault_code
);

    logic       desc_ok;
    logic [2:0] bit_sel;
    logic [2:0] nbytes;
    logic       map_deny;
    logic       idle;
    verdict_t   verdict;

    iop_desc_check #(.ADDR_W(ADDR_W)) u_desc (
        .present  (seg_present),
        .seg_type (seg_type),
        .limit    (seg_limit),
        .desc_ok  (desc_ok)
    );

    iop_window u_window (
        .map_word (mem_rdata),
        .bit_sel  (bit_sel),
        .nbytes   (nbytes),
        .deny     (map_deny)
    );

    iop_seq #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .desc_ok    (desc_ok),
        .seg_base   (seg_base),
        .seg_limit  (seg_limit),
        .port_addr  (port_addr),
        .acc_size   (acc_size),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .bit_sel    (bit_sel),
        .nbytes     (nbytes),
        .map_deny   (map_deny),
        .idle       (idle),
        .done       (done),
        .verdict    (verdict)
    );

    always_comb begin
        allow      = verdict.pass;
        gp_fault   = verdict.fault;
        fault_code = FAULT_ERR_CODE;
    end

    // R1: an absent segment faults on the next cycle without a read
    p_absent_fault_r1: assert property (@(posedge clk) disable iff (rst)
        (start && idle && !seg_present) |=> (done && gp_fault && !mem_req));

    // R1: wrong type faults without a read
    p_bad_type_r1: assert property (@(posedge clk) disable iff (rst)
        (start && idle && seg_type != TSS_AVAIL_TYPE) |=> (done && gp_fault && !mem_req));

    // R8: exactly one verdict while done, none otherwise
    p_verdict_excl_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot({allow, gp_fault}));

    p_quiet_verdict_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> !(allow || gp_fault));

    // R10: the cycle after reset is quiet
    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> !(done || mem_req || allow || gp_fault));

endmodule

// File: tb/test_io_perm_checker.sv
module test_io_perm_checker;

    typedef struct packed {
        logic        present;
        logic [3:0]  typ;
        logic [31:0] limit;
        logic [31:0] base;
        logic [15:0] port;
        logic [2:0]  size;
        logic [15:0] offv;
        logic [15:0] word;
        logic [1:0]  lat;
        logic        exp_allow;
        logic [1:0]  exp_reads;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd9,  32'h2000, 32'h1000, 16'h0000, 3'd1, 16'h0068, 16'h0000, 2'd0, 1'b0, 2'd0},
        '{1'b1, 4'd11, 32'h2000, 32'h1000, 16'h0000, 3'd1, 16'h0068, 16'h0000, 2'd0, 1'b0, 2'd0},
        '{1'b1, 4'd9,  32'd102,  32'h1000, 16'h0000, 3'd1, 16'h0068, 16'h0000, 2'd0, 1'b0, 2'd0},
        '{1'b1, 4'd9,  32'd103,  32'h1000, 16'h0000, 3'd1, 16'h0068, 16'h0000, 2'd1, 1'b0, 2'd1},
        '{1'b1, 4'd9,  32'h2000, 32'h1000, 16'h0000, 3'd1, 16'h0068, 16'h0000, 2'd0, 1'b1, 2'd2},
        '{1'b1, 4'd9,  32'h2000, 32'h1000, 16'h0003, 3'd1, 16'h0068, 16'h0008, 2'd1, 1'b0, 2'd2},
        '{1'b1, 4'd9,  32'h2000, 32'h1000, 16'h0003, 3'd2, 16'h0068, 16'h0010, 2'd2, 1'b0, 2'd2},
        '{1'b1, 4'd9,  32'h2000, 32'h1000, 16'h0005, 3'd4, 16'h0068, 16'h0200, 2'd0, 1'b1, 2'd2},
        '{1'b1, 4'd9,  32'h2000, 32'h1000, 16'h0005, 3'd4, 16'h0068, 16'h0100, 2'd1, 1'b0, 2'd2},
        '{1'b1, 4'd9,  32'h2000, 32'h1000, 16'h0007, 3'd4, 16'h0068, 16'hF87F, 2'd0, 1'b1, 2'd2},
        '{1'b1, 4'd9,  32'h2000, 32'h1000, 16'h0007, 3'd2, 16'h0068, 16'h0100, 2'd0, 1'b0, 2'd2},
        '{1'b1, 4'd9,  32'h0100, 32'h4000, 16'h0078, 3'd1, 16'h00F0, 16'h0000, 2'd2, 1'b1, 2'd2},
        '{1'b1, 4'd9,  32'h0100, 32'h4000, 16'h0080, 3'd1, 16'h00F0, 16'h0000, 2'd0, 1'b0, 2'd1},
        '{1'b1, 4'd9,  32'hFFFFFFFF, 32'h80000000, 16'hFFFF, 3'd1, 16'hFFFF, 16'hFF7F, 2'd0, 1'b1, 2'd2},
        '{1'b1, 4'd9,  32'h2000, 32'h1000, 16'h000A, 3'd1, 16'h0068, 16'h0004, 2'd3, 1'b0, 2'd2},
        '{1'b1, 4'd9,  32'h2000, 32'h1000, 16'h0006, 3'd2, 16'h0068, 16'hFF3F, 2'd1, 1'b1, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        seg_present = 1'b0;
    logic [3:0]  seg_type = 4'd0;
    logic [31:0] seg_base = '0;
    logic [31:0] seg_limit = '0;
    logic [15:0] port_addr = '0;
    logic [2:0]  acc_size = 3'd1;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        done;
    logic        allow;
    logic        gp_fault;
    logic [15:0] fault_code;

    io_perm_checker i_io_perm_checker (
        .clk(clk), .rst(rst), .start(start), .seg_present(seg_present),
        .seg_type(seg_type), .seg_base(seg_base), .seg_limit(seg_limit),
        .port_addr(port_addr), .acc_size(acc_size), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .allow(allow), .gp_fault(gp_fault), .fault_code(fault_code)
    );

    always #2ns clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // memory model state
    logic [31:0] cur_base;
    logic [15:0] cur_off;
    logic [15:0] cur_word;
    int          cur_lat;
    int          wait_cnt = 0;
    int          n_reads  = 0;
    logic [31:0] rd_addr [2];

    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid = 1'b0;
            wait_cnt   = 0;
        end else if (mem_req) begin
            if (wait_cnt >= cur_lat) begin
                mem_rvalid = 1'b1;
                mem_rdata  = (mem_addr == cur_base + 32'h66) ? cur_off : cur_word;
                if (n_reads < 2) rd_addr[n_reads] = mem_addr;
                n_reads++;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_done();
        for (int i = 0; i < 60 && !done; i++) @(negedge clk);
    endtask

    task automatic setup(input vec_t v);
        cur_base = v.base; cur_off = v.offv; cur_word = v.word; cur_lat = int'(v.lat);
        n_reads = 0; wait_cnt = 0;
        seg_present = v.present; seg_type = v.typ; seg_base = v.base;
        seg_limit = v.limit; port_addr = v.port; acc_size = v.size;
    endtask

    task automatic judge(input vec_t v, input int idx);
        logic [31:0] exp_a2;
        string tag;
        tag = $sformatf("vec%0d", idx);
        exp_a2 = v.base + 32'(v.offv) + 32'(v.port >> 3);
        check(done === 1'b1, "R8", {tag, " done"}, 64'(done), 64'd1);
        check(allow === v.exp_allow, "R6", {tag, " allow"}, 64'(allow), 64'(v.exp_allow));
        check(gp_fault === !v.exp_allow, "R6", {tag, " gp_fault"}, 64'(gp_fault), 64'(!v.exp_allow));
        if (!v.exp_allow)
            check(fault_code === 16'h0, "R6", {tag, " fault_code"}, 64'(fault_code), 64'd0);
        if (v.exp_reads == 2'd0)
            check(n_reads == 0, "R1", {tag, " reads"}, 64'(n_reads), 64'd0);
        else if (v.exp_reads == 2'd1)
            check(n_reads == 1, "R4", {tag, " reads"}, 64'(n_reads), 64'd1);
        else
            check(n_reads == 2, "R5", {tag, " reads"}, 64'(n_reads), 64'd2);
        if (v.exp_reads >= 2'd1)
            check(rd_addr[0] === v.base + 32'h66, "R2", {tag, " addr1"}, 64'(rd_addr[0]), 64'(v.base + 32'h66));
        if (v.exp_reads == 2'd2)
            check(rd_addr[1] === exp_a2, "R3", {tag, " addr2"}, 64'(rd_addr[1]), 64'(exp_a2));
        @(negedge clk);
        check(done === 1'b0 && allow === 1'b0 && gp_fault === 1'b0, "R8", {tag, " pulse end"},
              64'({done, allow, gp_fault}), 64'd0);
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check(done === 1'b0 && mem_req === 1'b0 && allow === 1'b0 && gp_fault === 1'b0,
              "R10", "during reset", 64'({done, mem_req, allow, gp_fault}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(done === 1'b0 && mem_req === 1'b0, "R10", "after reset",
              64'({done, mem_req}), 64'd0);

        // table walk: R1..R8
        for (int k = 0; k < NV; k++) begin
            setup(VECS[k]);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (VECS[k].exp_reads == 2'd0)
                check(done === 1'b1 && mem_req === 1'b0, "R1", $sformatf("vec%0d next-cycle fault", k),
                      64'({done, mem_req}), 64'd2);
            wait_done();
            judge(VECS[k], k);
            @(negedge clk);
        end

        // R9: restart with bad inputs mid-check is ignored
        begin
            vec_t v;
            v = '{1'b1, 4'd9, 32'h2000, 32'h1000, 16'h0000, 3'd1, 16'h0068, 16'h0008, 2'd3, 1'b1, 2'd2};
            setup(v);
            start = 1'b1;
            @(negedge clk);
            seg_present = 1'b0; port_addr = 16'h0003; seg_base = 32'h9000;
            @(negedge clk);
            @(negedge clk);
            start = 1'b0;
            wait_done();
            check(allow === 1'b1, "R9", "restart ignored verdict", 64'(allow), 64'd1);
            check(rd_addr[1] === 32'h1068, "R9", "captured port/base", 64'(rd_addr[1]), 64'h1068);
            begin
                int extra = 0;
                for (int i = 0; i < 8; i++) begin
                    @(negedge clk);
                    if (done) extra++;
                end
                check(extra == 0, "R9", "no second done", 64'(extra), 64'd0);
            end
        end

        // R7: no request while idle
        check(mem_req === 1'b0, "R7", "idle request", 64'(mem_req), 64'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4ns * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule